// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block fetches a 64-word configuration image from a three-wire serial memory. It drives a chip select, a serial clock and a serial data output, and it samples one serial data input. A single start strobe launches the whole readout. The block first checks an 8-bit pin-direction setting and goes ahead only if that setting holds the expected value.

Each word is fetched as its own transaction. Chip select rises and a start bit goes out. Next comes an 8-bit read command that carries the word address, then sixteen data bits are clocked in. The block keeps every word in an internal array and adds it to a 16-bit running sum. When the last word is in, the block raises a one-cycle done pulse, and the valid flag reports whether the sum matched the fixed signature. The host can read back any stored word through a combinational address port.

Every serial clock phase lasts a programmable number of system clock cycles. This lets the line rate meet the slow timing of the memory, roughly 10 µs per phase.

Top module: `cfg_rom_loader`

## Requirements
- R1: After a synchronous active-high reset, `cs`, `sclk`, `sdo`, `busy`, `done` and `valid` are all low.
- R2: Each word transaction opens with `cs` high and a start bit of 1, followed by eight command bits sent MSB first. The command value is 0x80 OR the word address. `sdo` only changes while `sclk` is low and stays stable for the whole high phase.
- R3: After the command, sixteen data bits are read MSB first. Each bit is sampled from `sdi` at the end of the `sclk` high phase that follows a low phase. The assembled word is stored at its address.
- R4: After the 16th data bit, `cs`, `sclk` and `sdo` are all low for exactly one phase before the next word starts.
- R5: Words are read at addresses 0 to 63 in ascending order, one transaction each, 64 in total.
- R6: When the sequence ends, `busy` falls and `done` is high for exactly one cycle. `valid` is then high only if the 16-bit wrap-around sum of all 64 words equals 0x1234.
- R7: If `dir_cfg` is not 0x09 when start is seen, no serial activity happens. `done` pulses on the next cycle, `busy` stays low and `valid` is low.
- R8: Every serial clock phase lasts exactly `DIV` system clock cycles.
- R9: A start strobe while `busy` is high is ignored, and the readout carries on unchanged.
- R10: `rd_data` returns the stored word at `rd_addr` combinationally. It holds its value after the sequence ends, until a later start overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that starts a readout |
| dir_cfg | input | 8 | Pin-direction setting; must be 0x09 for a readout |
| sdi | input | 1 | Serial data from the memory |
| rd_addr | input | 6 | Address of the stored word to read back |
| cs | output | 1 | Serial chip select |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the memory |
| busy | output | 1 | High while a readout is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| valid | output | 1 | Image checksum matched |
| rd_data | output | 16 | Stored word at `rd_addr` |

## Verification
The bench builds the block with `DIV` set to 3 instead of the default 500. This keeps a full 64-word readout to about ten thousand cycles, so two complete images, one good and one corrupted, fit in a single run. A phase of three cycles is still long enough to measure phase length, hold times of the data line and the width of the deselect gap cycle by cycle. A behavioural serial memory in the bench decodes each command and serves a computed image.

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader #(
  parameter int          DIV    = 500,
  parameter int          WORDS  = 64,
  parameter int          DW     = 16,
  parameter logic [15:0] CHECK  = 16'h1234,
  parameter logic [7:0]  DIR_OK = 8'h09
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [7:0]               dir_cfg,
  input  logic                     sdi,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic                     cs,
  output logic                     sclk,
  output logic                     sdo,
  output logic                     busy,
  output logic                     done,
  output logic                     valid,
  output logic [DW-1:0]            rd_data
);
  localparam int AW = $clog2(WORDS);
  localparam int CW = $clog2(DIV + 1);
  localparam int BW = $clog2(DW);
  localparam logic [7:0] RD_OP = 8'h80;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_RECV, S_GAP} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [BW-1:0] bitn;
  logic          hi;
  logic [7:0]    tx;
  logic [DW-2:0] rx;
  logic [DW-1:0] sum;
  logic [DW-1:0] mem [WORDS];

  wire          tick    = (cnt == '0);
  wire [DW-1:0] word_in = {rx, sdi};
  wire          wr_en   = (st == S_RECV) && tick && hi && (bitn == BW'(DW - 1));

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk)
    if (wr_en) mem[addr] <= word_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; addr <= '0; bitn <= '0; hi <= 1'b0;
      tx <= '0; rx <= '0; sum <= '0;
      cs <= 1'b0; sclk <= 1'b0; sdo <= 1'b0;
      busy <= 1'b0; done <= 1'b0; valid <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE) cnt <= tick ? CW'(DIV - 1) : cnt - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          valid <= 1'b0;
          sum   <= '0;
          addr  <= '0;
          if (dir_cfg == DIR_OK) begin
            st <= S_SEND; busy <= 1'b1; cs <= 1'b1; sdo <= 1'b1;
            tx <= RD_OP; bitn <= '0; hi <= 1'b0; cnt <= CW'(DIV - 1);
          end else begin
            done <= 1'b1;
          end
        end
        S_SEND: if (tick) begin
          if (!hi) begin
            sclk <= 1'b1; hi <= 1'b1;
          end else begin
            sclk <= 1'b0; hi <= 1'b0;
            if (bitn == BW'(8)) begin
              st <= S_RECV; bitn <= '0; sdo <= 1'b0;
            end else begin
              sdo <= tx[7]; tx <= tx << 1; bitn <= bitn + 1'b1;
            end
          end
        end
        S_RECV: if (tick) begin
          if (!hi) begin
            sclk <= 1'b1; hi <= 1'b1;
          end else begin
            sclk <= 1'b0; hi <= 1'b0;
            rx   <= word_in[DW-2:0];
            if (bitn == BW'(DW - 1)) begin
              sum <= sum + word_in;
              cs  <= 1'b0;
              st  <= S_GAP;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        S_GAP: if (tick) begin
          if (addr == AW'(WORDS - 1)) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1;
            valid <= (sum == CHECK);
          end else begin
            addr <= addr + 1'b1;
            tx   <= RD_OP | 8'(addr + 1'b1);
            cs   <= 1'b1; sdo <= 1'b1; bitn <= '0;
            st   <= S_SEND;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_quiet:   assert property (@(posedge clk) disable iff (rst) !busy |-> (!cs && !sclk));
  a_r4_clk_needs_cs: assert property (@(posedge clk) disable iff (rst) sclk |-> cs);
  a_r2_sdo_held:     assert property (@(posedge clk) disable iff (rst) sclk |-> $stable(sdo));
  a_r6_done_pulse:   assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r6_done_idle:    assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r9_busy_holds:   assert property (@(posedge clk) disable iff (rst) busy |=> (busy || done));
endmodule

// File: tb/test_cfg_rom_loader.sv
`timescale 1ns/1ps
module test_cfg_rom_loader;
  localparam int DIV = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sdi = 1'b0;
  logic [7:0] dir_cfg = 8'h09;
  logic [5:0] rd_addr = '0;
  logic cs, sclk, sdo, busy, done, valid;
  logic [15:0] rd_data;

  cfg_rom_loader #(.DIV(DIV)) i_cfg_rom_loader (
    .clk(clk), .rst(rst), .start(start), .dir_cfg(dir_cfg), .sdi(sdi),
    .rd_addr(rd_addr), .cs(cs), .sclk(sclk), .sdo(sdo), .busy(busy),
    .done(done), .valid(valid), .rd_data(rd_data));

  always #10 clk = ~clk;

  logic [15:0] img [64];
  int checks = 0, fails = 0, cyc = 0;
  int wcnt = 0, bits = 0, hicnt = 0, lowcnt = 0;
  logic pcs = 1'b0, psclk = 1'b0, psdo = 1'b0;
  logic [7:0] cmd = '0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // serial memory model, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cs && !pcs) begin
        if (wcnt > 0) chk(lowcnt == DIV, "R4 gap length", lowcnt, DIV);
        bits = 0;
      end
      if (!cs && pcs) begin
        chk(!sclk && !sdo, "R4 lines low after word", {sclk, sdo}, 0);
        chk(bits == 25, "R3 clocks per word", bits, 25);
        wcnt++;
        lowcnt = 0;
      end
      if (!cs) lowcnt++;
      if (sclk && psclk) chk(sdo == psdo, "R2 sdo held while sclk high", sdo, psdo);
      if (!sclk && psclk) chk(hicnt == DIV, "R8 phase length", hicnt, DIV);
      if (sclk) hicnt++; else hicnt = 0;
      if (sclk && !psclk && cs) begin
        if (bits == 0) chk(sdo == 1'b1, "R2 start bit", sdo, 1);
        else if (bits <= 8) begin
          cmd = {cmd[6:0], sdo};
          if (bits == 8) chk(cmd == (8'h80 | 8'(wcnt)), "R2 R5 command", cmd, 8'h80 | 8'(wcnt));
        end else sdi = img[wcnt[5:0]][24 - bits];
        bits++;
      end
      pcs = cs; psclk = sclk; psdo = sdo;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_load(input bit exp_valid, input bit poke);
    int n = 0;
    bit busy_ok = 1'b1;
    wcnt = 0;
    pulse_start();
    while (!done) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && n == 2000) start = 1'b1;
      else start = 1'b0;
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy_ok, "R9 busy held through readout", busy_ok, 1);
    chk(!busy, "R6 busy low at done", busy, 0);
    chk(valid == exp_valid, "R6 valid", valid, exp_valid);
    chk(wcnt == 64, "R5 word count", wcnt, 64);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
  endtask

  task automatic read_all(input string rq);
    for (int i = 0; i < 64; i++) begin
      rd_addr = 6'(i);
      #1;
      chk(rd_data == img[i], rq, rd_data, img[i]);
    end
  endtask

  task automatic test_reset();
    chk({cs, sclk, sdo, busy, done, valid} == 6'b0, "R1 reset state",
        {cs, sclk, sdo, busy, done, valid}, 0);
  endtask

  task automatic test_good();
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) begin
      img[i] = 16'(i * 16'h1f3b) ^ 16'h5a00;
      s += img[i];
    end
    img[63] = 16'h1234 - s;
    run_load(1'b1, 1'b1);
    read_all("R3 R10 stored word");
    repeat (50) @(negedge clk);
    rd_addr = 6'd63; #1;
    chk(rd_data == img[63], "R10 word persists", rd_data, img[63]);
    chk(valid, "R6 valid persists", valid, 1);
  endtask

  task automatic test_reject();
    bit quiet = 1'b1;
    dir_cfg = 8'h05;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done, "R7 done next cycle", done, 1);
    chk(!busy && !valid && !cs, "R7 no readout", {busy, valid, cs}, 0);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    repeat (100) begin
      @(negedge clk);
      if (cs || sclk || busy) quiet = 1'b0;
    end
    chk(quiet, "R7 lines stay idle", quiet, 1);
    dir_cfg = 8'h09;
  endtask

  task automatic test_bad();
    img[5] = img[5] + 16'd1;
    run_load(1'b0, 1'b0);
    rd_addr = 6'd5; #1;
    chk(rd_data == img[5], "R3 changed word stored", rd_data, img[5]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_good();
    test_reject();
    test_bad();
    summary();
  end
endmodule